// File: doc/BRIEF.md
# Move-Only Processor Core

This block is a very small processor whose whole instruction set consists of data moves. A program held in a local instruction store can put a constant into a register, copy a memory word into a register, or copy a register into a memory word. The only other instruction is a jump back to the first slot, which lets a program loop forever. The core has no arithmetic, no compare and no conditional branch. The only way to stop is to touch the reserved null address, which halts the core. Any malformed access also stops it, as an illegal-access fault.

Memory is word-addressed and is grouped into two-word cells that begin on even addresses. A memory instruction names a base register and an index register. The base holds the address of a cell. The index, which must be 0 or 1, picks the first or the second word of that cell. The effective address is the bitwise OR of the two, so no adder is needed. While the core is not running, a host writes the program and preloads data memory through side ports. The host can read data memory back through a debug read port at any time.

Top module: `movcore`

## Requirements
- R1: After reset the core reports pc = 0, halted = 0 and fault = 2'b00, and every register holds zero.
- R2: An instruction is 26 bits wide: opcode in [25:24] (00 load constant, 01 indexed load, 10 indexed store, 11 jump to slot 0), register A in [23:20], register B in [19:16], index register in [15:12], and a 12-bit constant in [11:0].
- R3: `running` equals `enable` and not `halted`. While it is high the core completes one instruction per clock. While `enable` is low, pc, registers and memory hold their values.
- R4: A load constant writes the constant into register A. An indexed load writes mem[ea] into register A, with register B as the base. An indexed store writes register B into mem[ea], with register A as the base.
- R5: A load that reads the word written by a store in the instruction just before it returns the stored value.
- R6: A jump sets pc to 0. Every other completed instruction advances pc by one, wrapping at the end of the instruction store.
- R7: The effective address is base OR index, so index 0 selects the even word of a cell and index 1 selects the odd word.
- R8: A load or store whose effective address is 0 halts the core with fault = 2'b01 and writes nothing.
- R9: A load or store with an odd base, an index value above 1, or an effective address beyond the data memory halts the core with fault = 2'b10 and writes nothing. This check takes priority over the null check.
- R10: Once halted, the core keeps pc, registers, memory, halted and fault unchanged until reset, even while `enable` stays high.
- R11: Program and debug memory writes take effect only while `running` is low. `dbg_rdata` always shows mem[dbg_addr].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows execution |
| prog_we | input | 1 | Instruction store write strobe |
| prog_addr | input | 4 | Instruction slot to write |
| prog_data | input | 26 | Instruction word to write |
| dbg_we | input | 1 | Data memory write strobe |
| dbg_addr | input | 8 | Data memory address for debug read and write |
| dbg_wdata | input | 12 | Data word to write |
| dbg_rdata | output | 12 | Data word at dbg_addr |
| running | output | 1 | Core is executing |
| halted | output | 1 | Core has stopped on a fault |
| fault | output | 2 | 00 none, 01 null access, 10 illegal access |
| pc | output | 4 | Program counter |

## Verification
The embedded properties assume that reset is applied before the first use, and that `enable` changes only between clock edges. They make no assumption about register contents, because every malformed base or index is a defined fault rather than a forbidden input. The random programs keep the constants mostly even and inside memory, and the index registers mostly at 0 or 1, so that long runs execute. A small share of odd, oversized and null values is mixed in so that both fault kinds are reached from random states. A bench interpreter predicts pc, the fault and the full memory image for each run.

// File: rtl/movcore.sv
module movcore #(
  parameter int WW  = 12,
  parameter int RW  = 4,
  parameter int PW  = 4,
  parameter int MAW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  prog_we,
  input  logic [PW-1:0]         prog_addr,
  input  logic [2+3*RW+WW-1:0]  prog_data,
  input  logic                  dbg_we,
  input  logic [MAW-1:0]        dbg_addr,
  input  logic [WW-1:0]         dbg_wdata,
  output logic [WW-1:0]         dbg_rdata,
  output logic                  running,
  output logic                  halted,
  output logic [1:0]            fault,
  output logic [PW-1:0]         pc
);
  localparam int IW    = 2 + 3*RW + WW;
  localparam int NREG  = 1 << RW;
  localparam int MDEP  = 1 << MAW;
  localparam int PDEP  = 1 << PW;

  localparam logic [1:0] OP_IMM = 2'b00;
  localparam logic [1:0] OP_LD  = 2'b01;
  localparam logic [1:0] OP_ST  = 2'b10;
  localparam logic [1:0] OP_JMP = 2'b11;

  logic [IW-1:0] rom [PDEP];
  logic [WW-1:0] rf  [NREG];
  logic [WW-1:0] mem [MDEP];

  logic [IW-1:0] ins;
  logic [1:0]    op;
  logic [RW-1:0] ra, rb, ri;
  logic [WW-1:0] imm, base, ofs, ea;
  logic          is_mem, bad, nul, step, commit;
  logic [MAW-1:0] ea_l;

  assign ins  = rom[pc];
  assign op   = ins[IW-1 -: 2];
  assign ra   = ins[IW-3 -: RW];
  assign rb   = ins[IW-3-RW -: RW];
  assign ri   = ins[IW-3-2*RW -: RW];
  assign imm  = ins[WW-1:0];

  assign base   = (op == OP_ST) ? rf[ra] : rf[rb];
  assign ofs    = rf[ri];
  assign ea     = base | ofs;
  assign ea_l   = ea[MAW-1:0];
  assign is_mem = (op == OP_LD) || (op == OP_ST);
  assign bad    = is_mem && (base[0] || (ofs > WW'(1)) || ((ea >> MAW) != '0));
  assign nul    = is_mem && !bad && (ea == '0);
  assign running = enable && !halted;
  assign step   = running;
  assign commit = step && !bad && !nul;
  assign dbg_rdata = mem[dbg_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= '0;
      halted <= 1'b0;
      fault  <= 2'b00;
      for (int k = 0; k < NREG; k++) rf[k] <= '0;
    end else if (step) begin
      if (bad || nul) begin
        halted <= 1'b1;
        fault  <= bad ? 2'b10 : 2'b01;
      end else begin
        case (op)
          OP_IMM:  rf[ra] <= imm;
          OP_LD:   rf[ra] <= mem[ea_l];
          default: ;
        endcase
        pc <= (op == OP_JMP) ? '0 : pc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit && op == OP_ST)
      mem[ea_l] <= rf[rb];
    else if (!running && dbg_we)
      mem[dbg_addr] <= dbg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!running && prog_we)
      rom[prog_addr] <= prog_data;
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(pc));

  // R6
  jump_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && op == OP_JMP) |=> (pc == '0));

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && op != OP_JMP && !bad && !nul) |=> (pc == $past(pc) + 1'b1));

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && $stable(fault)));

  // R8
  null_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && nul) |=> (halted && fault == 2'b01));

  // R9
  bad_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && bad) |=> (halted && fault == 2'b10));

  // R3
  run_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(running));
endmodule

// File: tb/movcore_tb_top.sv
`timescale 1ns/1ps
module movcore_tb_top;
  localparam int WW = 12, RW = 4, PW = 4, MAW = 8;
  localparam int IW = 2 + 3*RW + WW;
  localparam int NREG = 1 << RW, MDEP = 1 << MAW, PDEP = 1 << PW;

  logic clk = 0, rst_n = 0, enable = 0, prog_we = 0, dbg_we = 0;
  logic [PW-1:0] prog_addr = '0;
  logic [IW-1:0] prog_data = '0;
  logic [MAW-1:0] dbg_addr = '0;
  logic [WW-1:0] dbg_wdata = '0, dbg_rdata;
  logic running, halted;
  logic [1:0] fault;
  logic [PW-1:0] pc;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [IW-1:0] p_rom [PDEP];
  logic [WW-1:0] m_rf  [NREG];
  logic [WW-1:0] m_mem [MDEP];
  logic [PW-1:0] m_pc;
  logic          m_halt;
  logic [1:0]    m_fault;

  movcore #(.WW(WW), .RW(RW), .PW(PW), .MAW(MAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .running(running), .halted(halted), .fault(fault), .pc(pc));

  always #2 clk = ~clk;

  function automatic logic [IW-1:0] enc(input logic [1:0] op, input int a, input int b,
                                        input int i, input int k);
    return {op, RW'(a), RW'(b), RW'(i), WW'(k)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_step();
    logic [IW-1:0] w;
    logic [1:0] op;
    logic [WW-1:0] bs, of, ea;
    logic bad, nul;
    if (m_halt) return;
    w  = p_rom[m_pc];
    op = w[IW-1 -: 2];
    bs = (op == 2'b10) ? m_rf[w[IW-3 -: RW]] : m_rf[w[IW-3-RW -: RW]];
    of = m_rf[w[IW-3-2*RW -: RW]];
    ea = bs | of;
    bad = (op == 2'b01 || op == 2'b10) && (bs[0] || of > 1 || ea >= MDEP);
    nul = (op == 2'b01 || op == 2'b10) && !bad && ea == 0;
    if (bad || nul) begin
      m_halt = 1;
      m_fault = bad ? 2'b10 : 2'b01;
      return;
    end
    case (op)
      2'b00: m_rf[w[IW-3 -: RW]] = w[WW-1:0];
      2'b01: m_rf[w[IW-3 -: RW]] = m_mem[ea[MAW-1:0]];
      2'b10: m_mem[ea[MAW-1:0]] = m_rf[w[IW-3-RW -: RW]];
      default: ;
    endcase
    m_pc = (op == 2'b11) ? '0 : m_pc + 1'b1;
  endtask

  task automatic restart();
    @(negedge clk);
    enable = 0; rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < NREG; k++) m_rf[k] = '0;
    m_pc = '0; m_halt = 0; m_fault = 2'b00;
  endtask

  task automatic load_all();
    for (int k = 0; k < PDEP; k++) begin
      @(negedge clk); prog_we = 1; prog_addr = PW'(k); prog_data = p_rom[k];
    end
    for (int k = 0; k < MDEP; k++) begin
      @(negedge clk); prog_we = 0; dbg_we = 1; dbg_addr = MAW'(k); dbg_wdata = m_mem[k];
    end
    @(negedge clk); dbg_we = 0; prog_we = 0;
  endtask

  task automatic run(input int n);
    @(negedge clk); enable = 1;
    repeat (n) @(posedge clk);
    @(negedge clk); enable = 0;
    for (int k = 0; k < n; k++) m_step();
  endtask

  task automatic rd(input int a, output logic [WW-1:0] v);
    dbg_addr = MAW'(a); #0.5; v = dbg_rdata;
  endtask

  task automatic cmp_all(input string req);
    logic [WW-1:0] v;
    int bad = -1;
    logic [WW-1:0] bv = '0;
    chk({req, " pc"}, 32'(pc), 32'(m_pc));
    chk({req, " halted"}, 32'(halted), 32'(m_halt));
    chk({req, " fault"}, 32'(fault), 32'(m_fault));
    for (int k = 0; k < MDEP; k++) begin
      rd(k, v);
      if (v !== m_mem[k] && bad < 0) begin bad = k; bv = v; end
    end
    if (bad >= 0) chk({req, " mem"}, 32'(bv), 32'(m_mem[bad]));
    else chk({req, " mem"}, 0, 0);
  endtask

  task automatic clear_prog();
    for (int k = 0; k < PDEP; k++) p_rom[k] = enc(2'b11, 0, 0, 0, 0);
    for (int k = 0; k < MDEP; k++) m_mem[k] = WW'(k * 7 + 3);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] v;
    void'($urandom(32'h5EED));

    // R1: reset state, registers zero seen via store of r6 to mem[2]
    clear_prog();
    p_rom[0] = enc(2'b00, 4, 0, 0, 2);
    p_rom[1] = enc(2'b10, 4, 6, 5, 0);
    restart(); load_all();
    chk("R1 pc", 32'(pc), 0);
    chk("R1 halted", 32'(halted), 0);
    chk("R1 fault", 32'(fault), 0);
    chk("R3 running idle", 32'(running), 0);
    run(2);
    rd(2, v); chk("R1 reg zero", 32'(v), 0);
    chk("R4 pc after two", 32'(pc), 2);

    // R4 R5 R7: store to odd word then load it back next cycle, store to another cell
    clear_prog();
    p_rom[0] = enc(2'b00, 1, 0, 0, 16);
    p_rom[1] = enc(2'b00, 2, 0, 0, 1);
    p_rom[2] = enc(2'b00, 3, 0, 0, 12'hABC);
    p_rom[3] = enc(2'b10, 1, 3, 2, 0);
    p_rom[4] = enc(2'b01, 5, 1, 2, 0);
    p_rom[5] = enc(2'b00, 6, 0, 0, 40);
    p_rom[6] = enc(2'b10, 6, 5, 0, 0);
    restart(); load_all();
    run(7);
    rd(17, v); chk("R7 odd word", 32'(v), 32'h ABC);
    rd(16, v); chk("R7 even word untouched", 32'(v), 32'(WW'(16 * 7 + 3)));
    rd(40, v); chk("R5 forwarded load", 32'(v), 32'h ABC);
    cmp_all("R4");

    // R6: jump returns to slot 0, then loop continues
    run(2);
    chk("R6 jump", 32'(pc), 1);

    // R3: enable low holds state
    repeat (5) @(negedge clk);
    chk("R3 hold", 32'(pc), 1);

    // R11: debug write ignored while running
    @(negedge clk); enable = 1; dbg_we = 1; dbg_addr = 200; dbg_wdata = 12'h111;
    @(negedge clk); dbg_we = 0; enable = 0;
    m_step();
    rd(200, v); chk("R11 dbg write blocked", 32'(v), 32'(WW'(200 * 7 + 3)));

    // R8: null access halts, R10 frozen afterwards
    clear_prog();
    p_rom[0] = enc(2'b00, 3, 0, 0, 12'h055);
    p_rom[1] = enc(2'b10, 1, 3, 2, 0);
    p_rom[2] = enc(2'b00, 3, 0, 0, 9);
    restart(); load_all();
    run(6);
    chk("R8 halted", 32'(halted), 1);
    chk("R8 fault", 32'(fault), 1);
    chk("R10 pc frozen", 32'(pc), 1);
    rd(0, v); chk("R8 no write", 32'(v), 3);
    chk("R10 running low", 32'(running), 0);
    cmp_all("R10");

    // R9: odd base
    clear_prog();
    p_rom[0] = enc(2'b00, 1, 0, 0, 7);
    p_rom[1] = enc(2'b01, 4, 1, 0, 0);
    restart(); load_all(); run(3);
    chk("R9 odd base", 32'(fault), 2);
    // R9: index 2
    p_rom[0] = enc(2'b00, 1, 0, 0, 8);
    p_rom[1] = enc(2'b00, 2, 0, 0, 2);
    p_rom[2] = enc(2'b10, 1, 1, 2, 0);
    restart(); load_all(); run(4);
    chk("R9 big index", 32'(fault), 2);
    chk("R9 pc", 32'(pc), 2);
    // R9: beyond memory
    p_rom[0] = enc(2'b00, 1, 0, 0, 12'h400);
    p_rom[1] = enc(2'b01, 4, 1, 0, 0);
    p_rom[2] = enc(2'b00, 0, 0, 0, 0);
    restart(); load_all(); run(3);
    chk("R9 range", 32'(fault), 2);
    // R9 priority: base 0 with index 2 -> illegal not null
    p_rom[0] = enc(2'b00, 2, 0, 0, 2);
    p_rom[1] = enc(2'b01, 4, 1, 2, 0);
    restart(); load_all(); run(3);
    chk("R9 priority", 32'(fault), 2);

    // R2: random programs against bench interpreter
    for (int t = 0; t < 60; t++) begin
      for (int k = 0; k < MDEP; k++)
        m_mem[k] = ($urandom % 8 == 0) ? WW'($urandom) : WW'((($urandom % (MDEP/2 - 1)) + 1) * 2);
      for (int k = 0; k < PDEP - 1; k++) begin
        int sel = $urandom % 10;
        int kv;
        int r = $urandom % 20;
        if (r < 8) kv = ($urandom % 2);
        else if (r < 18) kv = (($urandom % (MDEP/2 - 1)) + 1) * 2;
        else kv = $urandom % 4096;
        if (sel < 4) p_rom[k] = enc(2'b00, $urandom % 16, 0, 0, kv);
        else if (sel < 7) p_rom[k] = enc(2'b01, $urandom % 16, $urandom % 16, $urandom % 16, 0);
        else p_rom[k] = enc(2'b10, $urandom % 16, $urandom % 16, $urandom % 16, 0);
      end
      p_rom[PDEP-1] = enc(2'b11, 0, 0, 0, 0);
      restart(); load_all();
      run(10 + $urandom % 30);
      cmp_all("R2 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule